// File: doc/BRIEF.md
# Pixel Column Hit Readout with Token Scan

This block holds the digital side of one column of hit-detecting pixel cells and reads out only the cells that hold a hit. Each cell takes a hit strobe, a test-inject strobe, a kill bit and a 7-bit thermometer code from its comparator bank. When a crossing tick arrives and the column is armed, the cell latches the hit and stores the amplitude as a 3-bit binary count. A 2-bit broadcast command sets the mode of every cell: idle, clear, drain or arm.

In drain mode the column takes a snapshot of the cells that hold hits and starts a pass. A token runs from row 0 toward the top row. The first cell in the snapshot that still holds its hit takes the token and offers its row address and amplitude on a valid/ready output stream. Back-pressure rules: once `out_valid_o` is high, the row and amplitude stay fixed until a cycle in which `out_ready_i` is also high, provided the command stays drain. If the command leaves drain, the offer is withdrawn and the pass pauses. It resumes at the same cell when drain returns. Each accepted transfer clears that cell and moves the token on. After the last cell of the pass is accepted, a done flag pulses for one cycle. A fast-OR output shows whether any unread hit is present anywhere in the column.

The command input and the status outputs are plain level signals. Every register is clocked by the read clock. The crossing clock is given to the block as a one-cycle tick in that clock domain.

Top module: `pixcol_readout`

## Requirements
- R1: The stored amplitude is the number of set bits in the 7-bit thermometer code, from 0 to 7, even when the code is not monotonic. For example, 0101010 gives 3.
- R2: A cell latches a hit only in a cycle with `bco_tick_i` high and command 11 (arm) or 10 (drain). A hit strobe without a tick, or with command 00 (idle) or 01 (clear), is ignored. `inject_i` acts exactly like a hit strobe.
- R3: A cell whose kill bit is high in the tick cycle does not latch a hit or an inject.
- R4: Within a pass, hit cells are offered in ascending row order, one per accepted transfer. `out_row_o` is the cell's row index and `out_amp_o` is its stored amplitude. Cells without a hit are skipped.
- R5: While `out_valid_o` is high and `out_ready_i` is low, with the command held at drain, `out_valid_o`, `out_row_o` and `out_amp_o` stay unchanged in the next cycle.
- R6: `col_done_o` goes high for exactly one cycle, the cycle after the transfer that empties the pass. In that cycle `out_valid_o` is low.
- R7: The snapshot holds only hits that were latched before the pass started. Hits latched during a pass, including on a lower row, are offered in the following pass. Several cells hit on the same tick are all read.
- R8: Command 01 (clear) empties every cell and ends any pass. In the next cycle `fast_or_o`, `out_valid_o` and `col_done_o` are low.
- R9: `fast_or_o` is high exactly when at least one cell holds an unread hit.
- R10: A cell that holds an unread hit ignores later hits and keeps its first amplitude until it is read.
- R11: A command other than drain drops `out_valid_o` at once. Going back to drain resumes the pass at the cell that was not yet accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Broadcast command: 00 idle, 01 clear, 10 drain, 11 arm |
| bco_tick_i | input | 1 | One-cycle crossing tick |
| hit_i | input | ROWS (128) | Hit strobe for each cell |
| inject_i | input | ROWS (128) | Test inject strobe for each cell |
| kill_i | input | ROWS (128) | Kill bit for each cell |
| therm_i | input | ROWS*7 (896) | Thermometer code of each cell; row r occupies bits [7r+6:7r] |
| out_valid_o | output | 1 | A row/amplitude word is offered |
| out_ready_i | input | 1 | The consumer accepts the word |
| out_row_o | output | 7 | Row address of the offered cell |
| out_amp_o | output | 3 | Amplitude of the offered cell |
| col_done_o | output | 1 | One-cycle pulse after a pass empties |
| fast_or_o | output | 1 | At least one unread hit is held |

## Verification
The assertions check several behaviours on every cycle:
- the offered word stays stable under back-pressure;
- the token grant has at most one bit set;
- the done pulse lasts one cycle and never coincides with a valid word;
- the clear command empties the column;
- a valid word always comes with fast-OR;
- a killed cell never latches a hit;
- a held hit keeps its first amplitude.

Only the bench scenarios can show the rest:
- the row order of a pass;
- the amplitude values for monotonic and non-monotonic codes;
- the deferral of a hit that arrives during a pass to the next pass;
- the pause and resume when the command leaves drain;
- the dropping of strobes that arrive without a tick or in idle.

// File: rtl/pixcol_pkg.sv
package pixcol_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_CLEAR = 2'b01,
    CMD_DRAIN = 2'b10,
    CMD_ARM   = 2'b11
  } col_cmd_e;
endpackage

// File: rtl/pix_therm_enc.sv
module pix_therm_enc #(
  parameter int IN_W  = 7,
  parameter int OUT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  therm_i,
  output logic [OUT_W-1:0] bin_o
);
  // Count the set bits, so a code with bubbles still gives a bounded value.
  always_comb begin
    bin_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      bin_o = bin_o + OUT_W'(therm_i[i]);
    end
  end
endmodule

// File: rtl/pix_cell.sv
module pix_cell #(
  parameter int THERM_W = 7,
  parameter int AMP_W   = $clog2(THERM_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               arm_i,
  input  logic               hit_i,
  input  logic               inject_i,
  input  logic               kill_i,
  input  logic [THERM_W-1:0] therm_i,
  input  logic               snap_i,
  input  logic               take_i,
  output logic               held_o,
  output logic               pend_o,
  output logic [AMP_W-1:0]   amp_o
);
  logic [AMP_W-1:0] amp_enc;
  logic             strike;
  logic             capture;

  pix_therm_enc #(.IN_W(THERM_W), .OUT_W(AMP_W)) u_enc (
    .therm_i (therm_i),
    .bin_o   (amp_enc)
  );

  assign strike  = arm_i & (hit_i | inject_i) & ~kill_i;
  assign capture = strike & (~held_o | take_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= 1'b0;
      pend_o <= 1'b0;
      amp_o  <= '0;
    end else if (clear_i) begin
      held_o <= 1'b0;
      pend_o <= 1'b0;
      amp_o  <= '0;
    end else begin
      if (capture) begin
        held_o <= 1'b1;
        amp_o  <= amp_enc;
      end else if (take_i) begin
        held_o <= 1'b0;
      end
      if (take_i)      pend_o <= 1'b0;
      else if (snap_i) pend_o <= held_o;
    end
  end

  // R3: a killed cell never turns on its hit latch
  a_r3_kill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> !$past(kill_i));

  // R10: an unread hit keeps its first amplitude
  a_r10_first_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && !take_i && !clear_i) |=> (held_o && $stable(amp_o)));

  // R7: a cell in the pass snapshot always still holds its hit
  a_r7_pend_in_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> held_o);
endmodule

// File: rtl/pix_token_chain.sv
module pix_token_chain #(
  parameter int ROWS   = 128,
  parameter int AMP_W  = 3,
  parameter int ADDR_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]       req_i,
  input  logic [ROWS*AMP_W-1:0] amp_i,
  output logic [ROWS-1:0]       grant_o,
  output logic                  any_o,
  output logic                  last_o,
  output logic [ADDR_W-1:0]     row_o,
  output logic [AMP_W-1:0]      amp_o
);
  logic [ROWS:0] tok;

  assign tok[0] = 1'b1;

  // The token passes a cell that makes no request and is taken by the first one that does.
  for (genvar g = 0; g < ROWS; g++) begin : g_link
    assign grant_o[g] = tok[g] & req_i[g];
    assign tok[g+1]   = tok[g] & ~req_i[g];
  end

  assign any_o  = ~tok[ROWS];
  assign last_o = any_o & ~|(req_i & ~grant_o);

  always_comb begin
    row_o = '0;
    amp_o = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (grant_o[i]) begin
        row_o = row_o | ADDR_W'(i);
        amp_o = amp_o | amp_i[i*AMP_W +: AMP_W];
      end
    end
  end
endmodule

// File: rtl/pixcol_readout.sv
module pixcol_readout
  import pixcol_pkg::*;
#(
  parameter int ROWS    = 128,
  parameter int THERM_W = 7,
  parameter int AMP_W   = $clog2(THERM_W + 1),
  parameter int ADDR_W  = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cmd_i,
  input  logic                    bco_tick_i,
  input  logic [ROWS-1:0]         hit_i,
  input  logic [ROWS-1:0]         inject_i,
  input  logic [ROWS-1:0]         kill_i,
  input  logic [ROWS*THERM_W-1:0] therm_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [ADDR_W-1:0]       out_row_o,
  output logic [AMP_W-1:0]        out_amp_o,
  output logic                    col_done_o,
  output logic                    fast_or_o
);
  col_cmd_e cmd;
  logic is_drain, is_clear, arm;
  logic pass_active, snap, fire;
  logic any_pend, last_pend;
  logic [ROWS-1:0]       held, pend, grant, take;
  logic [ROWS*AMP_W-1:0] amp_flat;

  assign cmd      = col_cmd_e'(cmd_i);
  assign is_drain = (cmd == CMD_DRAIN);
  assign is_clear = (cmd == CMD_CLEAR);
  assign arm      = bco_tick_i & ((cmd == CMD_ARM) | is_drain);

  for (genvar r = 0; r < ROWS; r++) begin : g_cell
    pix_cell #(.THERM_W(THERM_W), .AMP_W(AMP_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (is_clear),
      .arm_i    (arm),
      .hit_i    (hit_i[r]),
      .inject_i (inject_i[r]),
      .kill_i   (kill_i[r]),
      .therm_i  (therm_i[r*THERM_W +: THERM_W]),
      .snap_i   (snap),
      .take_i   (take[r]),
      .held_o   (held[r]),
      .pend_o   (pend[r]),
      .amp_o    (amp_flat[r*AMP_W +: AMP_W])
    );
  end

  pix_token_chain #(.ROWS(ROWS), .AMP_W(AMP_W), .ADDR_W(ADDR_W)) u_token (
    .req_i   (pend),
    .amp_i   (amp_flat),
    .grant_o (grant),
    .any_o   (any_pend),
    .last_o  (last_pend),
    .row_o   (out_row_o),
    .amp_o   (out_amp_o)
  );

  assign snap        = is_drain & ~pass_active & (|held);
  assign out_valid_o = pass_active & is_drain & any_pend;
  assign fire        = out_valid_o & out_ready_i;
  assign take        = grant & {ROWS{fire}};
  assign fast_or_o   = |held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_active <= 1'b0;
      col_done_o  <= 1'b0;
    end else if (is_clear) begin
      pass_active <= 1'b0;
      col_done_o  <= 1'b0;
    end else begin
      col_done_o <= fire & last_pend;
      if (snap)                   pass_active <= 1'b1;
      else if (fire && last_pend) pass_active <= 1'b0;
    end
  end

  // R4: the token grants at most one cell
  a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: an offered word holds under back-pressure
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (!is_drain || (out_valid_o && $stable(out_row_o) && $stable(out_amp_o))));

  // R6: the done flag is a single-cycle pulse with no word offered
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    col_done_o |=> !col_done_o);
  a_r6_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_done_o |-> !out_valid_o);

  // R8: the clear command empties the column
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (!fast_or_o && !out_valid_o && !col_done_o));

  // R9: an offered word implies an unread hit
  a_r9_valid_has_fastor: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> fast_or_o);
endmodule

// File: tb/pixcol_readout_tb.sv
`timescale 1ns/1ps
module pixcol_readout_tb;
  localparam int ROWS = 128;
  localparam int TW   = 7;
  localparam int AW   = 3;
  localparam int RW   = 7;
  localparam int MAX_CYC = 20000;

  localparam logic [1:0] C_IDLE = 2'b00, C_CLR = 2'b01, C_DRN = 2'b10, C_ARM = 2'b11;

  localparam int NV = 6;
  localparam int          V_ROW  [NV] = '{0, 127, 64, 33, 1, 100};
  localparam logic [6:0]  V_TH   [NV] = '{7'b0000000, 7'b1111111, 7'b0000111,
                                          7'b0101010, 7'b0000001, 7'b1000000};
  localparam int          V_AMP  [NV] = '{0, 7, 3, 3, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd_i = C_IDLE;
  logic bco_tick_i = 1'b0;
  logic [ROWS-1:0] hit_i = '0, inject_i = '0, kill_i = '0;
  logic [ROWS*TW-1:0] therm_i = '0;
  logic out_valid_o, out_ready_i = 1'b0, col_done_o, fast_or_o;
  logic [RW-1:0] out_row_o;
  logic [AW-1:0] out_amp_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pixcol_readout u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bco_tick_i(bco_tick_i),
    .hit_i(hit_i), .inject_i(inject_i), .kill_i(kill_i), .therm_i(therm_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_row_o(out_row_o),
    .out_amp_o(out_amp_o), .col_done_o(col_done_o), .fast_or_o(fast_or_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [1:0] c);
    cmd_i = c;
    @(negedge clk);
  endtask

  task automatic stage(input int r, input logic [6:0] th);
    hit_i[r] = 1'b1;
    therm_i[r*TW +: TW] = th;
  endtask

  task automatic tick();
    bco_tick_i = 1'b1;
    @(negedge clk);
    bco_tick_i = 1'b0;
    hit_i = '0;
    inject_i = '0;
  endtask

  task automatic clear_col();
    set_cmd(C_CLR);
    cmd_i = C_ARM;
  endtask

  task automatic expect_word(input string tag, input int row, input int amp, input bit last);
    int w = 0;
    while (!out_valid_o && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " valid"}, out_valid_o, 1);
    chk({tag, " row"}, out_row_o, row);
    chk({tag, " amp"}, out_amp_o, amp);
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
    if (last) begin
      chk({tag, " R6 done pulse"}, col_done_o, 1);
      chk({tag, " R6 no valid with done"}, out_valid_o, 0);
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(negedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R9 fast_or", fast_or_o, 0);
    chk("reset valid", out_valid_o, 0);
    chk("reset R6 done", col_done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: a single hit per entry; checks R1 amplitude and the R4 row.
    for (int k = 0; k < NV; k++) begin
      clear_col();
      stage(V_ROW[k], V_TH[k]);
      tick();
      chk("R9 fast_or after hit", fast_or_o, 1);
      set_cmd(C_DRN);
      expect_word("R1 R4 table", V_ROW[k], V_AMP[k], 1'b1);
      chk("R9 fast_or after read", fast_or_o, 0);
    end

    // R4 R7: three cells on one tick are read in ascending row order.
    clear_col();
    stage(90, 7'b0000011); stage(3, 7'b0011111); stage(127, 7'b0111111);
    tick();
    set_cmd(C_DRN);
    expect_word("R4 multi first", 3, 5, 1'b0);
    expect_word("R4 multi second", 90, 2, 1'b0);
    expect_word("R7 multi third", 127, 6, 1'b1);
    @(negedge clk);
    chk("R6 done single cycle", col_done_o, 0);

    // R3: a killed cell does not latch; R2: inject acts as a hit.
    clear_col();
    kill_i[20] = 1'b1;
    stage(20, 7'b1111111); stage(21, 7'b0000001);
    tick();
    kill_i[20] = 1'b0;
    inject_i[50] = 1'b1;
    therm_i[50*TW +: TW] = 7'b0001111;
    tick();
    set_cmd(C_DRN);
    expect_word("R3 kill skip", 21, 1, 1'b0);
    expect_word("R2 inject", 50, 4, 1'b1);

    // R2: no tick, or tick in idle: nothing latched.
    clear_col();
    stage(10, 7'b0000111);
    @(negedge clk);
    hit_i = '0;
    chk("R2 no tick ignored", fast_or_o, 0);
    cmd_i = C_IDLE;
    stage(11, 7'b0000111);
    tick();
    chk("R2 idle tick ignored", fast_or_o, 0);
    set_cmd(C_DRN);
    repeat (3) @(negedge clk);
    chk("R2 nothing offered", out_valid_o, 0);

    // R5: stall holds the word.
    clear_col();
    stage(40, 7'b0000011); stage(41, 7'b0000111);
    tick();
    set_cmd(C_DRN);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R5 stall valid", out_valid_o, 1);
    chk("R5 stall row", out_row_o, 40);
    chk("R5 stall amp", out_amp_o, 2);
    expect_word("R5 after stall", 40, 2, 1'b0);
    expect_word("R5 next", 41, 3, 1'b1);

    // R7: a hit during a pass waits for the next pass, even on a lower row.
    clear_col();
    stage(5, 7'b0000001); stage(10, 7'b0000011);
    tick();
    set_cmd(C_DRN);
    expect_word("R7 pass1 first", 5, 1, 1'b0);
    stage(2, 7'b1111111);
    tick();
    expect_word("R7 pass1 second", 10, 2, 1'b1);
    expect_word("R7 deferred hit", 2, 7, 1'b1);

    // R10: first hit amplitude kept.
    clear_col();
    stage(7, 7'b0000011);
    tick();
    stage(7, 7'b1111111);
    tick();
    set_cmd(C_DRN);
    expect_word("R10 first hit", 7, 2, 1'b1);

    // R11: leaving drain pauses, return resumes.
    clear_col();
    stage(4, 7'b0000001); stage(6, 7'b0000111);
    tick();
    set_cmd(C_DRN);
    expect_word("R11 before pause", 4, 1, 1'b0);
    cmd_i = C_IDLE;
    #1;
    chk("R11 paused valid", out_valid_o, 0);
    @(negedge clk);
    set_cmd(C_DRN);
    expect_word("R11 resumed", 6, 3, 1'b1);

    // R8: clear mid-pass empties everything.
    clear_col();
    stage(60, 7'b0000111); stage(61, 7'b0000111);
    tick();
    set_cmd(C_DRN);
    expect_word("R8 pre clear", 60, 3, 1'b0);
    set_cmd(C_CLR);
    chk("R8 fast_or cleared", fast_or_o, 0);
    set_cmd(C_DRN);
    repeat (2) @(negedge clk);
    chk("R8 valid cleared", out_valid_o, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule